// File: doc/BRIEF.md
# GPIO Port with Level-Sense Detection

This block is a general-purpose I/O port with one small configuration register per pin. Each register picks the pin's drive direction and whether its input buffer is connected. It also picks the pin's sense mode: off, active-high or active-low. Pad inputs pass through a two-flop synchronizer before they reach the readable input word. A disconnected pin reads as zero there and never takes part in sensing.

A single aggregated detect output goes high when any connected pin with sense enabled sits at its chosen level. It then stays high until every sensing pin has been away from its level for a fixed number of consecutive cycles. Only after that can it rise again. A per-pin latch records which pins matched, and a write of one clears it.

The output value comes from a word register that can be written whole or changed bit by bit with set and clear masks. Any pin can be handed to a peripheral, whose value and enable then win over the port's own registers.

Top module: `gsp_port`

## Requirements
- R1: After reset, in_word, pad_out, pad_oe, detect and hit_latch are all zero, and every pin is configured as an input with its buffer connected and sense off.
- R2: A configuration write (cfg_we with cfg_pin selecting the pin) stores a 4-bit value. Bit 0 is direction (1 = output), bit 1 is input disconnect (1 = disconnected), and bits 3:2 are sense (00 or 01 = off, 10 = high, 11 = low). With no override, pad_oe of that pin follows the direction bit.
- R3: A change on pad_in appears in in_word two rising clock edges later, and not after only one.
- R4: A pin whose input buffer is disconnected reads 0 in in_word. It never raises detect or its hit_latch bit, whatever its pad level and sense mode.
- R5: When a connected pin with sense enabled reaches its sense level at the synchronizer output, detect rises on the next clock edge. A high-sense pin matches a 1 and a low-sense pin matches a 0. Pad-to-detect latency is three edges.
- R6: Once high, detect falls only after three consecutive cycles in which no pin matches its sense level. A shorter gap leaves detect high, and after a fall a new match raises it again.
- R7: A bit of hit_latch is set in every cycle its pin matches. It is cleared by a one in the same bit of latch_clr, and a match in the same cycle wins over the clear.
- R8: out_wr loads out_wdata into the output word. In the same cycle out_set then sets bits and out_clr clears bits, with clear winning over set. The word drives pad_out on every pin without an override.
- R9: When ovr_en of a pin is 1, its pad_out comes from ovr_out and its pad_oe from ovr_oe. The output word and direction bit of that pin are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_pin | input | 5 | Pin index for the configuration write |
| cfg_wdata | input | 4 | Configuration value {sense[1:0], disconnect, direction} |
| out_wr | input | 1 | Load the output word |
| out_wdata | input | 32 | Value for the output word |
| out_set | input | 32 | Bits to set in the output word |
| out_clr | input | 32 | Bits to clear in the output word |
| latch_clr | input | 32 | Write-one-to-clear mask for hit_latch |
| pad_in | input | 32 | Asynchronous pad levels |
| ovr_en | input | 32 | Peripheral override enable per pin |
| ovr_out | input | 32 | Peripheral output value |
| ovr_oe | input | 32 | Peripheral output enable |
| pad_out | output | 32 | Value driven to the pads |
| pad_oe | output | 32 | Output enable to the pads |
| in_word | output | 32 | Synchronized, buffer-masked input value |
| detect | output | 1 | Aggregated level-sense detect |
| hit_latch | output | 32 | Pins that have matched their sense level |

## Verification
A stuck or miscounted quiet counter shows on detect within a few cycles. detect falls one cycle early or late after the pads leave their sense level, or it drops during a one-cycle gap that should leave it high. A wrong synchronizer depth moves in_word one edge away from the two-edge mark, and that shifts the first detect edge by the same amount. A mask error in the connect or sense decode shows at once: a disconnected pin leaks into in_word or hit_latch, or a low-sense pin fails to fire on the cycle after its configuration write.

// File: rtl/gsp_pkg.sv
package gsp_pkg;

    typedef enum logic [1:0] {
        SNS_OFF  = 2'b00,
        SNS_RSVD = 2'b01,
        SNS_HIGH = 2'b10,
        SNS_LOW  = 2'b11
    } sense_e;

    typedef struct packed {
        sense_e sense;
        logic   disc;
        logic   dir;
    } pin_cfg_t;

    localparam int CFG_W = $bits(pin_cfg_t);

    localparam pin_cfg_t CFG_RESET = '{sense: SNS_OFF, disc: 1'b0, dir: 1'b0};

endpackage

// File: rtl/gsp_cfg_bank.sv
module gsp_cfg_bank
    import gsp_pkg::*;
#(
    parameter int NPINS = 32,
    localparam int IDX_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_pin,
    input  pin_cfg_t         cfg_wdata,
    output logic [NPINS-1:0] dir_mask,
    output logic [NPINS-1:0] conn_mask,
    output logic [NPINS-1:0] sense_en,
    output logic [NPINS-1:0] sense_lvl
);

    typedef struct packed {
        pin_cfg_t [NPINS-1:0] cfg;
    } bank_t;

    bank_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < NPINS; i++) begin
            if (cfg_we && (cfg_pin == IDX_W'(i))) begin
                st_d.cfg[i] = cfg_wdata;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NPINS; i++) begin
                st_q.cfg[i] <= CFG_RESET;
            end
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < NPINS; g++) begin : g_decode
        assign dir_mask[g]  = st_q.cfg[g].dir;
        assign conn_mask[g] = ~st_q.cfg[g].disc;
        assign sense_en[g]  = st_q.cfg[g].sense[1];
        assign sense_lvl[g] = (st_q.cfg[g].sense == SNS_HIGH);
    end

endmodule

// File: rtl/gsp_sync.sv
module gsp_sync #(
    parameter int NPINS  = 32,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] pad_in,
    output logic [NPINS-1:0] sync_out
);

    typedef struct packed {
        logic [STAGES-1:0][NPINS-1:0] stg;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d        = st_q;
        st_d.stg[0] = pad_in;
        for (int s = 1; s < STAGES; s++) begin
            st_d.stg[s] = st_q.stg[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sync_out = st_q.stg[STAGES-1];

endmodule

// File: rtl/gsp_detect.sv
module gsp_detect #(
    parameter int NPINS = 32,
    parameter int REARM = 3,
    localparam int CNT_W = $clog2(REARM + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] in_sync,
    input  logic [NPINS-1:0] conn_mask,
    input  logic [NPINS-1:0] sense_en,
    input  logic [NPINS-1:0] sense_lvl,
    input  logic [NPINS-1:0] latch_clr,
    output logic             detect,
    output logic [NPINS-1:0] hit_latch
);

    localparam logic [CNT_W-1:0] LAST_QUIET = CNT_W'(REARM - 1);

    typedef struct packed {
        logic             fired;
        logic [CNT_W-1:0] quiet;
        logic [NPINS-1:0] latch;
    } det_t;

    det_t st_d, st_q;

    logic [NPINS-1:0] match;
    logic             any_match;

    assign match     = conn_mask & sense_en & ~(in_sync ^ sense_lvl);
    assign any_match = |match;

    always_comb begin
        st_d       = st_q;
        st_d.latch = (st_q.latch & ~latch_clr) | match;
        if (!st_q.fired) begin
            st_d.quiet = '0;
            if (any_match) begin
                st_d.fired = 1'b1;
            end
        end else if (any_match) begin
            st_d.quiet = '0;
        end else if (st_q.quiet == LAST_QUIET) begin
            st_d.fired = 1'b0;
            st_d.quiet = '0;
        end else begin
            st_d.quiet = st_q.quiet + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign detect    = st_q.fired;
    assign hit_latch = st_q.latch;

    // Independent run-length of no-match cycles, used only by the checks below.
    logic [CNT_W-1:0] chk_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chk_run <= '0;
        end else if (any_match) begin
            chk_run <= '0;
        end else if (chk_run != CNT_W'(REARM)) begin
            chk_run <= chk_run + 1'b1;
        end
    end

    AST_RISE_NEEDS_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(detect) |-> $past(any_match)) else $error("detect rose with no match"); // R5

    AST_HOLD_WHILE_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (detect && any_match) |=> detect) else $error("detect dropped during match"); // R6

    AST_FALL_AFTER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(detect) |-> (chk_run >= CNT_W'(REARM))) else $error("detect fell too early"); // R6

    AST_DISC_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_latch & ~$past(hit_latch) & ~$past(conn_mask)) == '0) else $error("disconnected pin latched"); // R4

    AST_LATCH_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
        (hit_latch & $past(latch_clr) & ~$past(match)) == '0) else $error("latch not cleared"); // R7

endmodule

// File: rtl/gsp_out.sv
module gsp_out #(
    parameter int NPINS = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             out_wr,
    input  logic [NPINS-1:0] out_wdata,
    input  logic [NPINS-1:0] out_set,
    input  logic [NPINS-1:0] out_clr,
    input  logic [NPINS-1:0] dir_mask,
    input  logic [NPINS-1:0] ovr_en,
    input  logic [NPINS-1:0] ovr_out,
    input  logic [NPINS-1:0] ovr_oe,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe
);

    typedef struct packed {
        logic [NPINS-1:0] word;
    } out_t;

    out_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (out_wr) begin
            st_d.word = out_wdata;
        end
        st_d.word = (st_d.word | out_set) & ~out_clr;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    for (genvar g = 0; g < NPINS; g++) begin : g_mux
        assign pad_out[g] = ovr_en[g] ? ovr_out[g] : st_q.word[g];
        assign pad_oe[g]  = ovr_en[g] ? ovr_oe[g]  : dir_mask[g];
    end

    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.word & $past(out_clr)) == '0) else $error("clear mask ignored"); // R8

    AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (~st_q.word & $past(out_set) & ~$past(out_clr)) == '0) else $error("set mask ignored"); // R8

endmodule

// File: rtl/gsp_port.sv
module gsp_port
    import gsp_pkg::*;
#(
    parameter int NPINS       = 32,
    parameter int SYNC_STAGES = 2,
    parameter int REARM       = 3,
    localparam int IDX_W = (NPINS > 1) ? $clog2(NPINS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_pin,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             out_wr,
    input  logic [NPINS-1:0] out_wdata,
    input  logic [NPINS-1:0] out_set,
    input  logic [NPINS-1:0] out_clr,
    input  logic [NPINS-1:0] latch_clr,
    input  logic [NPINS-1:0] pad_in,
    input  logic [NPINS-1:0] ovr_en,
    input  logic [NPINS-1:0] ovr_out,
    input  logic [NPINS-1:0] ovr_oe,
    output logic [NPINS-1:0] pad_out,
    output logic [NPINS-1:0] pad_oe,
    output logic [NPINS-1:0] in_word,
    output logic             detect,
    output logic [NPINS-1:0] hit_latch
);

    logic [NPINS-1:0] dir_mask;
    logic [NPINS-1:0] conn_mask;
    logic [NPINS-1:0] sense_en;
    logic [NPINS-1:0] sense_lvl;
    logic [NPINS-1:0] sync_raw;

    gsp_cfg_bank #(.NPINS(NPINS)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_pin   (cfg_pin),
        .cfg_wdata (pin_cfg_t'(cfg_wdata)),
        .dir_mask  (dir_mask),
        .conn_mask (conn_mask),
        .sense_en  (sense_en),
        .sense_lvl (sense_lvl)
    );

    gsp_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pad_in   (pad_in),
        .sync_out (sync_raw)
    );

    assign in_word = sync_raw & conn_mask;

    gsp_detect #(.NPINS(NPINS), .REARM(REARM)) u_det (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_sync   (in_word),
        .conn_mask (conn_mask),
        .sense_en  (sense_en),
        .sense_lvl (sense_lvl),
        .latch_clr (latch_clr),
        .detect    (detect),
        .hit_latch (hit_latch)
    );

    gsp_out #(.NPINS(NPINS)) u_out (
        .clk       (clk),
        .rst_n     (rst_n),
        .out_wr    (out_wr),
        .out_wdata (out_wdata),
        .out_set   (out_set),
        .out_clr   (out_clr),
        .dir_mask  (dir_mask),
        .ovr_en    (ovr_en),
        .ovr_out   (ovr_out),
        .ovr_oe    (ovr_oe),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe)
    );

    AST_DISC_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_word & ~conn_mask) == '0) else $error("disconnected pin visible"); // R4

endmodule

// File: tb/gsp_port_test.sv
module gsp_port_test;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 4;

    // {out word, ovr_en, ovr_out, ovr_oe, expected pad_out, expected pad_oe}
    localparam logic [5:0][31:0] VEC [NV] = '{
        '{32'hA5A5_A5A5, 32'h0000_0000, 32'h0000_0000, 32'h0000_0000, 32'hA5A5_A5A5, 32'h0000_FFFF},
        '{32'hA5A5_A5A5, 32'hFF00_0000, 32'h1200_0000, 32'hFF00_0000, 32'h12A5_A5A5, 32'hFF00_FFFF},
        '{32'hFFFF_0000, 32'h0000_00FF, 32'h0000_0000, 32'h0000_0000, 32'hFFFF_0000, 32'h0000_FF00},
        '{32'h0000_0001, 32'hFFFF_FFFF, 32'h8000_0000, 32'h0F0F_0F0F, 32'h8000_0000, 32'h0F0F_0F0F}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_pin = '0;
    logic [3:0]  cfg_wdata = '0;
    logic        out_wr = 1'b0;
    logic [31:0] out_wdata = '0;
    logic [31:0] out_set = '0;
    logic [31:0] out_clr = '0;
    logic [31:0] latch_clr = '0;
    logic [31:0] pad_in = '0;
    logic [31:0] ovr_en = '0;
    logic [31:0] ovr_out = '0;
    logic [31:0] ovr_oe = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;
    logic [31:0] in_word;
    logic        detect;
    logic [31:0] hit_latch;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    gsp_port uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_pin(cfg_pin), .cfg_wdata(cfg_wdata),
        .out_wr(out_wr), .out_wdata(out_wdata), .out_set(out_set), .out_clr(out_clr),
        .latch_clr(latch_clr), .pad_in(pad_in), .ovr_en(ovr_en), .ovr_out(ovr_out),
        .ovr_oe(ovr_oe), .pad_out(pad_out), .pad_oe(pad_oe), .in_word(in_word),
        .detect(detect), .hit_latch(hit_latch)
    );

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr_cfg(input int pin, input logic [3:0] val);
        cfg_we    = 1'b1;
        cfg_pin   = 5'(pin);
        cfg_wdata = val;
        tick(1);
        cfg_we    = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1 reset state
        chk("R1 pad_out", pad_out, 32'h0);
        chk("R1 pad_oe", pad_oe, 32'h0);
        chk("R1 in_word", in_word, 32'h0);
        chk("R1 detect", {31'h0, detect}, 32'h0);
        chk("R1 hit_latch", hit_latch, 32'h0);

        // R2 direction bit: pins 0..15 as outputs
        for (int p = 0; p < 16; p++) wr_cfg(p, 4'b0001);
        chk("R2 pad_oe from dir", pad_oe, 32'h0000_FFFF);

        // R8/R9 vector table
        for (int v = 0; v < NV; v++) begin
            out_wr    = 1'b1;
            out_wdata = VEC[v][5];
            ovr_en    = VEC[v][4];
            ovr_out   = VEC[v][3];
            ovr_oe    = VEC[v][2];
            tick(1);
            out_wr = 1'b0;
            chk("R9 R8 pad_out vector", pad_out, VEC[v][1]);
            chk("R9 R2 pad_oe vector", pad_oe, VEC[v][0]);
        end
        ovr_en = '0;

        // R8 set/clear priority
        out_wr = 1'b1; out_wdata = 32'h0000_00F0; out_set = 32'h1; out_clr = 32'h10;
        tick(1);
        out_wr = 1'b0; out_set = 32'h100; out_clr = '0;
        chk("R8 write set clear", pad_out, 32'h0000_00E1);
        tick(1);
        out_set = '0;
        chk("R8 set only", pad_out, 32'h0000_01E1);

        // R3 two-edge synchronizer
        pad_in = 32'h1234_5678;
        tick(1);
        chk("R3 one edge", in_word, 32'h0);
        tick(1);
        chk("R3 two edges", in_word, 32'h1234_5678);

        // R4 disconnect pin 4 (kept as output)
        wr_cfg(4, 4'b0011);
        chk("R4 disconnected reads 0", in_word, 32'h1234_5668);

        // R5 detect latency on high-sense pin 7
        pad_in = '0;
        tick(3);
        wr_cfg(7, 4'b1001);
        pad_in = 32'h80;
        tick(2);
        chk("R5 no detect after 2 edges", {31'h0, detect}, 32'h0);
        tick(1);
        chk("R5 detect after 3 edges", {31'h0, detect}, 32'h1);
        chk("R7 latch pin7", hit_latch, 32'h80);

        // R6 re-arm after three quiet cycles
        pad_in = '0;
        tick(4);
        chk("R6 held after 4 edges", {31'h0, detect}, 32'h1);
        tick(1);
        chk("R6 fell after 5 edges", {31'h0, detect}, 32'h0);
        pad_in = 32'h80;
        tick(3);
        chk("R6 re-raised", {31'h0, detect}, 32'h1);
        pad_in = '0;
        tick(1);
        pad_in = 32'h80;
        for (int k = 0; k < 8; k++) begin
            tick(1);
            chk("R6 short gap keeps detect", {31'h0, detect}, 32'h1);
        end
        pad_in = '0;
        tick(8);
        chk("R6 fell after long gap", {31'h0, detect}, 32'h0);

        // R7 write-one-to-clear
        latch_clr = 32'h80;
        tick(1);
        latch_clr = '0;
        chk("R7 latch cleared", hit_latch, 32'h0);

        // R4 disconnected pin with sense high never detects
        wr_cfg(4, 4'b1010);
        pad_in = 32'h10;
        tick(6);
        chk("R4 no detect", {31'h0, detect}, 32'h0);
        chk("R4 no latch", hit_latch, 32'h0);
        chk("R4 in_word zero", in_word, 32'h0);

        // R5 low-sense pin 9 fires on level 0
        pad_in = '0;
        tick(3);
        wr_cfg(9, 4'b1100);
        tick(1);
        chk("R5 low sense detect", {31'h0, detect}, 32'h1);
        chk("R7 latch pin9", hit_latch, 32'h200);
        pad_in = 32'h200;
        tick(6);
        chk("R6 low sense released", {31'h0, detect}, 32'h0);

        finish_run();
    end

endmodule